// File: doc/BRIEF.md
# SPI Master Byte Transfer Engine with Access-Cleared Flags

This block is an 8-bit serial peripheral master that sits on a small register bus with two locations: a data location and a status/control location. Software writes a byte to the data location; the byte waits in a transmit buffer and moves into the shift engine as soon as no transfer is running. The engine then produces eight serial clock pulses, sending the byte most significant bit first on the output line while collecting a byte from the input line, in the mode where the clock idles low and both sides sample on the rising edge.

The serial clock is derived from the bus clock through a two-bit rate field. When the eighth bit has been collected, the received byte moves into the receive data register and the receive-full flag rises in that same cycle. That flag comes down only through a fixed access order: a status read made while the flag is up, followed later by a data read. The transmit-empty flag drops on a data write and rises again when the buffered byte enters the shift engine. An interrupt request follows receive-full, gated by an enable bit.

Top module: `spi_master_flags`

## Requirements
- R1: After reset the status location reads 0x40 (only transmit-empty set), the serial clock is low and the interrupt request is low.
- R2: Status/control layout: bit 7 receive-full (read only), bit 6 transmit-empty (read only), bit 5 receive interrupt enable, bits 1:0 rate select; writing the status location updates bits 5 and 1:0. Rate select 0, 1, 2, 3 gives a serial clock period of 2, 8, 32, 128 bus cycles.
- R3: The serial clock idles low and gives exactly 8 pulses per byte; the output line carries the transmitted byte most significant bit first, stable on each rising edge.
- R4: The input line is sampled on each rising serial clock edge, most significant bit first; on the cycle the last falling edge ends the transfer, the received byte appears in the data location and receive-full rises.
- R5: A status read made while receive-full is set, followed by a data read, clears receive-full.
- R6: A data read not preceded by a status read taken while receive-full was set leaves receive-full set, including when a status read happened before the flag rose.
- R7: A data write clears transmit-empty in the next cycle; with the engine idle, the byte loads one cycle later and transmit-empty is set again.
- R8: A byte written during a transfer stays buffered with transmit-empty clear until the running transfer ends, then starts the next transfer without further access.
- R9: The interrupt request is high exactly when receive-full and the receive interrupt enable are both set.
- R10: A transfer that completes while receive-full is still set replaces the receive data with the new byte and leaves receive-full set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 status/control, 1 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (drives the clear sequence) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected location, combinational |
| spi_sck | output | 1 | Serial clock to the slave |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench sweeps every transmit byte at the fastest rate against a bench slave that returns an arithmetic pattern, and measures the clock period at all four rates; a divider off by one stage or a bit order reversal shows up as a wrong period or a mirrored byte. It drives the clear sequence in the wrong order, with a status read taken before the flag rose and with a data read alone, where a design that cleared on any data read would drop the flag early. It writes a second byte during a running transfer and leaves the first result unread, so a design that loaded over the running shift, lost the buffered byte or refused to overwrite the receive register returns the wrong data. Transmit-empty is sampled the cycle after the write and the cycle after that, catching a load that comes late or never resets the flag.

// File: rtl/spi_mf_pkg.sv
// Package: shared constants for the SPI master block.
// Assumes an 8-bit status/control layout placed from the top bit down.
package spi_mf_pkg;
    localparam int ADDR_STATUS = 0;
    localparam int ADDR_DATA   = 1;
    // Bit offsets measured from the most significant bit of a register.
    localparam int OFS_RXF = 0;
    localparam int OFS_TXE = 1;
    localparam int OFS_IE  = 2;
endpackage

// File: rtl/spi_mf_baud.sv
// Module: serial clock tick generator.
// Emits one tick every 2^(2*rate) bus cycles while run is high; each tick
// is one half period of the serial clock. Counter clears when run is low.
module spi_mf_baud #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int HALF_LOG_MAX = 2 * ((1 << RATE_W) - 1);
    localparam int CNT_W        = HALF_LOG_MAX + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    // Terminal count for the selected half period.
    always_comb begin
        half_m1 = (CNT_W'(1) << {rate, 1'b0}) - CNT_W'(1);
        tick    = run && (cnt == half_m1);
    end

    // Half-period counter, restarts at every tick and when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/spi_mf_shift.sv
// Module: mode-0 shift engine, MSB first.
// On load it takes a byte and starts; rising clock ticks sample miso,
// falling ticks shift. done pulses combinationally on the final falling
// tick, with rx_next holding the completed received byte.
module spi_mf_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_next
);
    localparam int BIT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sr;
    logic [BIT_W-1:0]  bitcnt;
    logic              samp;
    logic              last;

    // Completion decode and next shift value.
    always_comb begin
        last    = (bitcnt == BIT_W'(DATA_W - 1));
        done    = busy && tick && sck && last;
        rx_next = {sr[DATA_W-2:0], samp};
        mosi    = sr[DATA_W-1];
    end

    // Shift state: load, sample on rise, shift on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '0;
            bitcnt <= '0;
            samp   <= 1'b0;
            sck    <= 1'b0;
            busy   <= 1'b0;
        end else if (load) begin
            sr     <= load_data;
            bitcnt <= '0;
            sck    <= 1'b0;
            busy   <= 1'b1;
        end else if (busy && tick) begin
            if (!sck) begin
                sck  <= 1'b1;
                samp <= miso;
            end else begin
                sck    <= 1'b0;
                sr     <= rx_next;
                bitcnt <= bitcnt + BIT_W'(1);
                if (last)
                    busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_mf_regs.sv
// Module: bus registers and flags.
// Holds the transmit buffer, receive register, control bits and the
// receive-full / transmit-empty flags with their access-order clear rules.
// Assumes single-cycle read and write strobes.
module spi_mf_regs
    import spi_mf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_next,
    output logic              load,
    output logic [DATA_W-1:0] load_data,
    output logic [RATE_W-1:0] rate,
    output logic              ie,
    output logic              rx_full,
    output logic              tx_empty,
    output logic              irq
);
    logic [DATA_W-1:0] tx_buf;
    logic [DATA_W-1:0] rx_reg;
    logic [DATA_W-1:0] status;
    logic              armed;
    logic              wr_data, rd_data, rd_stat;

    // Access decode, status image and load request.
    always_comb begin
        wr_data   = wr && (addr == 1'(ADDR_DATA));
        rd_data   = rd && (addr == 1'(ADDR_DATA));
        rd_stat   = rd && (addr == 1'(ADDR_STATUS));
        status    = '0;
        status[DATA_W-1-OFS_RXF] = rx_full;
        status[DATA_W-1-OFS_TXE] = tx_empty;
        status[DATA_W-1-OFS_IE]  = ie;
        status[RATE_W-1:0]       = rate;
        rdata     = (addr == 1'(ADDR_DATA)) ? rx_reg : status;
        load      = !busy && !tx_empty;
        load_data = tx_buf;
        irq       = rx_full && ie;
    end

    // Control bits written through the status location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate <= '0;
            ie   <= 1'b0;
        end else if (wr && (addr == 1'(ADDR_STATUS))) begin
            rate <= wdata[RATE_W-1:0];
            ie   <= wdata[DATA_W-1-OFS_IE];
        end
    end

    // Transmit buffer and transmit-empty flag; a write beats a same-cycle load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf   <= '0;
            tx_empty <= 1'b1;
        end else if (wr_data) begin
            tx_buf   <= wdata;
            tx_empty <= 1'b0;
        end else if (load) begin
            tx_empty <= 1'b1;
        end
    end

    // Receive register, receive-full flag and the armed clear step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_reg  <= '0;
            rx_full <= 1'b0;
            armed   <= 1'b0;
        end else begin
            if (done)
                rx_reg <= rx_next;
            if (done)
                rx_full <= 1'b1;
            else if (rd_data && armed)
                rx_full <= 1'b0;
            if (rd_data)
                armed <= 1'b0;
            else if (rd_stat && rx_full)
                armed <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_master_flags.sv
// Module: SPI master top level.
// Wires the register file, tick generator and shift engine together.
// Assumes a bus master issuing one-cycle strobes on bus_wr / bus_rd.
module spi_master_flags #(
    parameter int DATA_W = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              irq
);
    logic              busy, done, load, tick, ie, rx_full, tx_empty;
    logic [DATA_W-1:0] rx_next, load_data;
    logic [RATE_W-1:0] rate;

    spi_mf_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .done(done),
        .rx_next(rx_next), .load(load), .load_data(load_data), .rate(rate),
        .ie(ie), .rx_full(rx_full), .tx_empty(tx_empty), .irq(irq)
    );

    spi_mf_baud #(.RATE_W(RATE_W)) i_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate), .tick(tick)
    );

    spi_mf_shift #(.DATA_W(DATA_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
        .tick(tick), .miso(spi_miso), .busy(busy), .sck(spi_sck),
        .mosi(spi_mosi), .done(done), .rx_next(rx_next)
    );
endmodule

// File: rtl/spi_mf_chk.sv
// Module: property checker for spi_master_flags, attached by bind.
module spi_mf_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_addr,
    input logic bus_wr,
    input logic bus_rd,
    input logic spi_sck,
    input logic busy,
    input logic rx_full,
    input logic tx_empty
);
    // R4
    rx_full_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> (!spi_sck && $past(spi_sck)));

    // R5
    rx_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(bus_rd && bus_addr));

    // R7
    tx_empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr) |=> !tx_empty);

    // R8
    tx_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_empty) |=> !tx_empty);

    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(spi_sck));
endmodule

bind spi_master_flags spi_mf_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .spi_sck(spi_sck), .busy(busy), .rx_full(rx_full),
    .tx_empty(tx_empty)
);

// File: tb/test_spi_master_flags.sv
module test_spi_master_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_mosi, spi_miso, irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_master_flags i_spi_master_flags (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
    );

    // Bench slave: shifts out on falling clock, captures on rising clock.
    logic [7:0] slv = '0, slv_next = '0, s_cap = '0;
    int         s_cnt = 0;
    assign spi_miso = slv[7];
    always @(posedge spi_sck) s_cap <= {s_cap[6:0], spi_mosi};
    always @(negedge spi_sck) begin
        if (s_cnt == 7) begin
            slv   <= slv_next;
            s_cnt <= 0;
        end else begin
            slv   <= {slv[6:0], 1'b0};
            s_cnt <= s_cnt + 1;
        end
    end

    // Serial clock period monitor and pulse counter, sampled at negedge.
    int cyc = 0, last_rise = 0, period = 0, pulses = 0;
    logic sck_q = 1'b0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (spi_sck && !sck_q) begin
            period    = cyc - last_rise;
            last_rise = cyc;
            pulses    = pulses + 1;
        end
        sck_q = spi_sck;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_strobe(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd_strobe(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic peek(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_full();
        logic [7:0] v;
        peek(1'b0, v);
        while (!v[7]) begin
            @(negedge clk);
            peek(1'b0, v);
        end
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        peek(1'b0, v);
        while (!v[6]) begin
            @(negedge clk);
            peek(1'b0, v);
        end
    endtask

    // One full transfer with the proper clear sequence.
    task automatic xfer(input logic [7:0] tx, input logic [7:0] sv, input int rsel);
        logic [7:0] v;
        int p0;
        slv = sv; slv_next = sv; s_cnt = 0;
        p0 = pulses;
        wr_strobe(1'b1, tx);
        wait_full();
        check(s_cap == tx, "R3 mosi byte", s_cap, tx);
        check(pulses - p0 == 8, "R3 pulse count", pulses - p0, 8);
        check(period == (2 << (2 * rsel)), "R2 sck period", period, 2 << (2 * rsel));
        rd_strobe(1'b0, v);
        rd_strobe(1'b1, v);
        check(v == sv, "R4 rx data", v, sv);
        peek(1'b0, v);
        check(v[7] == 1'b0, "R5 rx_full cleared", v[7], 0);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] sv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        peek(1'b0, v);
        check(v == 8'h40, "R1 status", v, 8'h40);
        check(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);

        // R7 transmit-empty clear and reload timing, rate 0
        slv = 8'h00; slv_next = 8'h00; s_cnt = 0;
        wr_strobe(1'b1, 8'hA5);
        peek(1'b0, v);
        check(v[6] == 1'b0, "R7 tx_empty after write", v[6], 0);
        @(negedge clk); peek(1'b0, v);
        check(v[6] == 1'b1, "R7 tx_empty after load", v[6], 1);
        wait_full();
        rd_strobe(1'b0, v);
        rd_strobe(1'b1, v);

        // R2 R3 R4 R5 sweep all bytes at rate 0
        for (int i = 0; i < 256; i++) begin
            sv = 8'((i * 37 + 11) & 255);
            xfer(8'(i), sv, 0);
        end

        // R2 rates 1..3
        for (int r = 1; r < 4; r++) begin
            wr_strobe(1'b0, 8'(r));
            peek(1'b0, v);
            check(v[1:0] == 2'(r), "R2 rate readback", v[1:0], r);
            xfer(8'(8'h3C ^ r), 8'(8'hC3 + r), r);
            xfer(8'(8'h81 + r), 8'(8'h7E - r), r);
        end
        wr_strobe(1'b0, 8'h00);

        // R6 data read without armed status read
        rd_strobe(1'b0, v);                      // status read before flag rises
        slv = 8'h96; slv_next = 8'h96; s_cnt = 0;
        wr_strobe(1'b1, 8'h11);
        wait_full();
        rd_strobe(1'b1, v);
        peek(1'b0, v);
        check(v[7] == 1'b1, "R6 flag kept after unarmed read", v[7], 1);
        rd_strobe(1'b1, v);
        peek(1'b0, v);
        check(v[7] == 1'b1, "R6 flag kept after second read", v[7], 1);
        rd_strobe(1'b0, v);
        rd_strobe(1'b0, v);
        rd_strobe(1'b1, v);
        check(v == 8'h96, "R6 rx data", v, 8'h96);
        peek(1'b0, v);
        check(v[7] == 1'b0, "R5 clear after armed read", v[7], 0);

        // R8 R10 back-to-back with overrun
        slv = 8'h5A; slv_next = 8'hE1; s_cnt = 0;
        wr_strobe(1'b1, 8'hC7);
        @(negedge clk);
        wr_strobe(1'b1, 8'h2B);
        peek(1'b0, v);
        check(v[6] == 1'b0, "R8 tx_empty held while busy", v[6], 0);
        wait_full();
        peek(1'b1, v);
        check(v == 8'h5A, "R8 first rx", v, 8'h5A);
        @(negedge clk); peek(1'b0, v);
        check(v[6] == 1'b1, "R8 second byte loaded", v[6], 1);
        repeat (40) @(negedge clk);
        peek(1'b0, v);
        check(v[7] == 1'b1, "R10 flag still set", v[7], 1);
        check(s_cap == 8'h2B, "R8 second mosi byte", s_cap, 8'h2B);
        rd_strobe(1'b0, v);
        rd_strobe(1'b1, v);
        check(v == 8'hE1, "R10 rx overwritten", v, 8'hE1);

        // R9 interrupt gating
        slv = 8'h33; slv_next = 8'h33; s_cnt = 0;
        wr_strobe(1'b1, 8'h44);
        wait_full();
        check(irq == 1'b0, "R9 irq disabled", irq, 0);
        wr_strobe(1'b0, 8'h20);
        check(irq == 1'b1, "R9 irq enabled", irq, 1);
        rd_strobe(1'b0, v);
        check(v == 8'hE0, "R2 status image", v, 8'hE0);
        rd_strobe(1'b1, v);
        check(irq == 1'b0, "R9 irq after clear", irq, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule